// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash device. Once the last write of a program or erase command has gone out, the host pulses `start`, and the block then watches the operation until it finishes. It reads a status byte from the device again and again at one address, which is latched at the start. Each time, it compares status bit 7 with the value that bit 7 will have when the operation is done. For a program, that value is bit 7 of the byte being written. For an erase, it is always 1.

Status bit 5 is the device's time-limit flag. When bit 7 does not match and bit 5 is set, the block reads the device once more and makes its decision on that read, because bit 7 can change in the same cycle that bit 5 rises. Bit 7 can settle before the other data bits do. So after any match, the block makes one last read to capture a clean byte. The result stays on `done`, `pass` and `data_out` until the next start.

The block has five states. `S_IDLE` is the state after reset. `S_PROBE` issues the repeating status reads. `S_RECHECK` is the one extra read made after bit 5 is seen. `S_CAPTURE` is the final read that gets the full byte. `S_DONE` holds the result.

The transitions are:
- **launch**: `S_IDLE` or `S_DONE` to `S_PROBE` when `start` is high.
- **hit**: `S_PROBE` or `S_RECHECK` to `S_CAPTURE` when bit 7 matches.
- **repoll**: `S_PROBE` to `S_PROBE` when there is a mismatch with bit 5 clear.
- **flag**: `S_PROBE` to `S_RECHECK` when there is a mismatch with bit 5 set.
- **give-up**: `S_RECHECK` to `S_DONE` on a mismatch, or `S_PROBE` to `S_DONE` when the poll limit is reached. The result is fail.
- **finish**: `S_CAPTURE` to `S_DONE`. The result is pass.

A read is accepted only on a cycle where both `rd_req` and `rd_ack` are high.

Top module: `flash_poll_ctrl`

## Requirements
- R1: Every read carries the address that was on `valid_addr` at the accepted start. `rd_addr` does not change while a request is waiting for its acknowledge.
- R2: After reset the block is idle: `rd_req`, `busy`, `done` and `pass` are all 0. No read is issued before a start pulse. `rd_req` is never high while `done` is high.
- R3: A status read whose bit 7 equals the expected bit causes exactly one more read. The block then finishes with `pass`=1, and `data_out` holds the byte from that last read.
- R4: A status read whose bit 7 differs from the expected bit, with bit 5 clear, is followed by another status read to the same address.
- R5: A status read whose bit 7 differs, with bit 5 set, is followed by exactly one recheck read. If bit 7 of the recheck matches, the block goes on as in R3. If it does not match, the block finishes with `pass`=0 and `data_out` holds the recheck byte.
- R6: When `op_erase`=1, the expected bit 7 is 1 whatever `expect_data` holds. When `op_erase`=0, the expected bit 7 is `expect_data[7]`.
- R7: `done`, `pass` and `data_out` keep their values until the next `start`.
- R8: A `start` pulse while `busy` is high has no effect on the address, the expected bit or the outcome.
- R9: With `MAX_POLLS`=N>0, the Nth consecutive status read that mismatches with bit 5 clear ends the operation with `pass`=0, and `data_out` holds that byte. If N-1 such reads are followed by a match, the operation still passes. With N=0 there is no limit.
- R10: Once `rd_req` is raised, it stays high until `rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse marking the end of the last command write |
| op_erase | input | 1 | 1 for an erase, 0 for a program |
| valid_addr | input | AW | Address used for the status reads |
| expect_data | input | DW | Byte being programmed |
| rd_req | output | 1 | Read request to the device |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid while it is high |
| rd_data | input | DW | Byte read from the device |
| busy | output | 1 | An operation is being polled |
| done | output | 1 | A result is held |
| pass | output | 1 | 1 if the operation completed |
| data_out | output | DW | Byte from the final read |

## Verification
The bench builds status streams at random. Each stream is a run of mismatching reads with bit 5 clear, followed by one of three endings: a direct match, bit 5 followed by a matching recheck, or bit 5 followed by a failing recheck. Comparing these endings shows whether the block takes the recheck path only when bit 5 is set, and whether it judges the outcome on the recheck byte and not on the flagged one.

Erase runs use `expect_data` with bit 7 clear. This shows whether the expected bit comes from the operation type or from the data. Counting the reads exposes a missing or doubled capture read.

Directed runs cover the following:
- exactly `MAX_POLLS` mismatches, against one mismatch fewer;
- an immediate match;
- a start pulse in the middle of an operation.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PROBE   = 3'd1,
        S_RECHECK = 3'd2,
        S_CAPTURE = 3'd3,
        S_DONE    = 3'd4
    } poll_state_t;
endpackage

// File: rtl/flash_poll_match.sv
module flash_poll_match #(
    parameter int DW       = 8,
    parameter int READY_IX = 7,
    parameter int LIMIT_IX = 5
) (
    input  logic [DW-1:0] status,
    input  logic          want_ready,
    output logic          hit,
    output logic          limit_flag
);
    always_comb begin
        hit        = (status[READY_IX] == want_ready);
        limit_flag = status[LIMIT_IX];
    end
endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_last
);
    localparam int LIMIT = (MAX_POLLS == 0) ? 1 : MAX_POLLS;
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (clear)  count_q <= '0;
        else if (bump)   count_q <= count_q + 1'b1;
    end

    generate
        if (MAX_POLLS == 0) begin : g_unbounded
            assign at_last = 1'b0;
        end else begin : g_bounded
            assign at_last = (count_q == CW'(LIMIT - 1));
        end
    endgenerate
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 8,
    parameter int MAX_POLLS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_erase,
    input  logic [AW-1:0] valid_addr,
    input  logic [DW-1:0] expect_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [DW-1:0] data_out
);
    localparam int READY_IX = DW - 1;
    localparam int LIMIT_IX = DW - 3;

    poll_state_t state_q, state_d;

    logic [AW-1:0] addr_q;
    logic          want_q;
    logic          pass_q;
    logic [DW-1:0] byte_q;

    logic hit, limit_flag, at_last;
    logic launch, taken, repoll, give_up;

    flash_poll_match #(
        .DW(DW), .READY_IX(READY_IX), .LIMIT_IX(LIMIT_IX)
    ) u_match (
        .status(rd_data), .want_ready(want_q),
        .hit(hit), .limit_flag(limit_flag)
    );

    flash_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk(clk), .rst_n(rst_n), .clear(launch),
        .bump(repoll), .at_last(at_last)
    );

    assign rd_req  = (state_q == S_PROBE) || (state_q == S_RECHECK) || (state_q == S_CAPTURE);
    assign busy    = rd_req;
    assign done    = (state_q == S_DONE);
    assign rd_addr = addr_q;
    assign pass    = pass_q;
    assign data_out = byte_q;

    assign launch  = start && ((state_q == S_IDLE) || (state_q == S_DONE));
    assign taken   = rd_req && rd_ack;
    assign repoll  = taken && (state_q == S_PROBE) && !hit && !limit_flag;
    assign give_up = (repoll && at_last) ||
                     (taken && (state_q == S_RECHECK) && !hit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: if (launch) state_d = S_PROBE;
            S_PROBE: if (taken) begin
                if (hit)             state_d = S_CAPTURE;
                else if (limit_flag) state_d = S_RECHECK;
                else if (at_last)    state_d = S_DONE;
            end
            S_RECHECK: if (taken) state_d = hit ? S_CAPTURE : S_DONE;
            S_CAPTURE: if (taken) state_d = S_DONE;
            default:   state_d = S_IDLE;
        endcase
    end

    // operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            want_q <= 1'b1;
            pass_q <= 1'b0;
            byte_q <= '0;
        end else if (launch) begin
            addr_q <= valid_addr;
            want_q <= op_erase | expect_data[READY_IX];
            pass_q <= 1'b0;
        end else if (taken && (state_q == S_CAPTURE)) begin
            pass_q <= 1'b1;
            byte_q <= rd_data;
        end else if (give_up) begin
            pass_q <= 1'b0;
            byte_q <= rd_data;
        end
    end
endmodule

// File: rtl/flash_poll_ctrl_sva.sv
module flash_poll_ctrl_sva #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [DW-1:0] data_out
);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> $stable(rd_addr));

    assert_no_read_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !rd_req);

    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(pass) && $stable(data_out));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !rd_ack |=> busy && $stable(rd_addr));
endmodule

bind flash_poll_ctrl flash_poll_ctrl_sva #(.AW(AW), .DW(DW)) u_sva (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .busy(busy), .done(done),
    .pass(pass), .data_out(data_out)
);

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam int MAXP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic [AW-1:0] valid_addr = '0;
    logic [DW-1:0] expect_data = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done, pass;
    logic [DW-1:0] data_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0]    scr [64];
    int            idx = 0;
    int            wait_left = 0;
    logic [AW-1:0] want_addr = '0;
    int            addr_bad = 0;

    always #10 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .valid_addr(valid_addr), .expect_data(expect_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass), .data_out(data_out)
    );

    // device model: answers each request after a random delay
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rd_ack) begin
            rd_ack <= 1'b0;
            wait_left <= int'($urandom_range(0, 3));
        end else if (rd_req) begin
            if (wait_left == 0) begin
                if (rd_addr != want_addr) addr_bad <= addr_bad + 1;
                rd_ack  <= 1'b1;
                rd_data <= scr[idx % 64];
                idx     <= idx + 1;
            end else begin
                wait_left <= wait_left - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void ref_model(input logic e7, output logic p,
                                      output logic [7:0] d, output int nreads);
        int i = 0;
        int polls = 0;
        p = 1'b0; d = '0;
        while (i < 64) begin
            logic [7:0] s = scr[i]; i++;
            if (s[7] == e7) begin
                p = 1'b1; d = scr[i]; i++; break;
            end else if (s[5]) begin
                logic [7:0] r = scr[i]; i++;
                if (r[7] == e7) begin p = 1'b1; d = scr[i]; i++; end
                else begin p = 1'b0; d = r; end
                break;
            end else begin
                polls++;
                if (MAXP > 0 && polls >= MAXP) begin p = 1'b0; d = s; break; end
            end
        end
        nreads = i;
    endfunction

    function automatic logic [7:0] miss_byte(input logic e7, input logic flag);
        logic [7:0] b = 8'($urandom);
        b[7] = ~e7; b[5] = flag;
        return b;
    endfunction

    // kind: 0 direct match, 1 flag then match, 2 flag then fail
    task automatic build(input logic e7, input int misses, input int kind);
        int k = 0;
        for (int j = 0; j < 64; j++) scr[j] = 8'($urandom);
        for (int j = 0; j < misses; j++) begin scr[k] = miss_byte(e7, 1'b0); k++; end
        if (kind != 0) begin scr[k] = miss_byte(e7, 1'b1); k++; end
        if (kind == 2) begin
            scr[k] = miss_byte(e7, $urandom_range(0, 1) == 1); k++;
        end else begin
            scr[k] = 8'($urandom); scr[k][7] = e7; k++;
        end
    endtask

    task automatic run_op(input logic erase, input logic [7:0] ed,
                          input logic [AW-1:0] a, input bit disturb, input string req);
        logic       e7, ep;
        logic [7:0] ed_out;
        int         nr, guard;
        e7 = erase | ed[7];
        ref_model(e7, ep, ed_out, nr);
        @(negedge clk);
        idx = 0; addr_bad = 0; want_addr = a;
        op_erase = erase; expect_data = ed; valid_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_erase = ~erase; expect_data = ~ed; valid_addr = ~a;
        guard = 0;
        while (!done && guard < 400) begin
            if (disturb && guard == 3) start = 1'b1; // R8: start while busy
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
        check(done == 1'b1, req, "done reached", int'(done), 1);
        check(pass == ep, req, "pass", int'(pass), int'(ep));
        check(data_out == ed_out, req, "data_out", int'(data_out), int'(ed_out));
        check(idx == nr, req, "read count", idx, nr);
        check(addr_bad == 0, "R1", "address mismatches", addr_bad, 0);
        for (int j = 0; j < 4; j++) @(negedge clk);
        check(done && pass == ep && data_out == ed_out && !rd_req, "R7",
              "result held", int'(data_out), int'(ed_out));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int j = 0; j < 64; j++) scr[j] = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check(!rd_req && !busy && !done && !pass, "R2", "reset outputs",
              int'({rd_req, busy, done, pass}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!rd_req && !done, "R2", "idle without start", int'(rd_req), 0);

        // R3: immediate match
        build(1'b1, 0, 0); run_op(1'b0, 8'hA5, 20'h12345, 1'b0, "R3");
        // R4: several plain misses then match
        build(1'b0, 5, 0); run_op(1'b0, 8'h3C, 20'h00F00, 1'b0, "R4");
        // R5: flag then matching recheck, and flag then failing recheck
        build(1'b1, 2, 1); run_op(1'b0, 8'h81, 20'h0ABCD, 1'b0, "R5");
        build(1'b1, 0, 2); run_op(1'b0, 8'hFF, 20'h00001, 1'b0, "R5");
        // R6: erase with data bit 7 clear expects 1
        build(1'b1, 3, 0); run_op(1'b1, 8'h00, 20'h54321, 1'b0, "R6");
        build(1'b1, 1, 2); run_op(1'b1, 8'h7F, 20'h54321, 1'b0, "R6");
        // R9: limit boundary
        build(1'b0, MAXP, 0); run_op(1'b0, 8'h11, 20'h00200, 1'b0, "R9");
        build(1'b0, MAXP - 1, 0); run_op(1'b0, 8'h11, 20'h00200, 1'b0, "R9");
        // R8: start during operation ignored
        build(1'b1, 6, 1); run_op(1'b0, 8'hC0, 20'h0F0F0, 1'b1, "R8");

        // random mix (R3 R4 R5 R6)
        for (int t = 0; t < 40; t++) begin
            logic       er = 1'($urandom);
            logic [7:0] ed = 8'($urandom);
            logic       e7 = er | ed[7];
            build(e7, int'($urandom_range(0, 12)), int'($urandom_range(0, 2)));
            run_op(er, ed, AW'($urandom), 1'($urandom_range(0, 3) == 0), "R5");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule